// File: doc/BRIEF.md
# Pulse Interval Gate Generator

This block produces the count-enable window for a time-interval measurement. A conditioned input signal is first brought onto the reference clock, and an optional polarity inversion is applied to it. A small state machine then opens a window on the chosen starting edge and closes it on the chosen ending edge. While the window is open, an external reference-clock counter (not part of this block) counts. The number of reference clocks in the window is therefore either one full input period or one pulse width.

The block has two modes. In period mode, the window runs from one active edge to the next active edge of the same direction. In width mode, it spans one active-level pulse. Without inversion, the active edge is rising and the active level is high. With inversion, they become falling and low.

A host uses the block as a single-shot measurement. It pulses `clear` to restart the gate (the external counter is cleared at the same time). It then polls `countEn` and `convDone` until the conversion ends, and reads the count. Each arm measures exactly one cycle or one pulse.

Top module: `pulse_window_gen`

## Requirements
- R1: While `rstN` is low, and after it is released, `countEn` and `convDone` are both 0 until a window opens.
- R2: In period mode (`widthMode`=0), `countEn` stays high for exactly as many clock cycles as lie between two consecutive active edges of the input.
- R3: In width mode (`widthMode`=1), `countEn` stays high for exactly as many clock cycles as the input spends at its active level in one pulse.
- R4: With `invertPol`=0, the active edge is rising and the active level is 1. With `invertPol`=1, the active edge is falling and the active level is 0.
- R5: `countEn` changes on the third rising clock edge after the input transition that opens or closes the window. This is two synchronizer stages plus one state register.
- R6: `convDone` rises on the same clock edge on which a completed window drops `countEn`. The two flags are never high together.
- R7: Once `convDone` is set, further input edges have no effect. `countEn` stays 0 and `convDone` stays 1 until the next `clear` or reset.
- R8: After a `clear`, the opening edge is accepted only after the input has been seen at its inactive level. A pulse already in progress when the block is armed is not measured.
- R9: A one-cycle `clear` pulse drops both flags on the next clock edge, even in the middle of an open window, and re-arms the block for a new measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of the gate, one cycle wide |
| sigIn | input | 1 | Conditioned input signal, asynchronous to clk |
| widthMode | input | 1 | 0: period window, 1: pulse-width window |
| invertPol | input | 1 | 1 inverts the input before edge detection |
| countEn | output | 1 | Counting in progress (window open) |
| convDone | output | 1 | End of conversion, held until restart |

## Verification
The main function is driven by a set of pulse trains that differ in mode, polarity, active length and inactive length. These include single-cycle pulses and single-cycle gaps, so that a window one clock too short or too long, or ended by the wrong edge direction, shows up as a wrong count.

Each train carries three active pulses. As a result, a gate that reopens after completion inflates the count. Separate directed runs do the following:
- pin the three-edge latency at both ends of the window;
- arm during an active pulse, which tells apart a gate that waits for the inactive level from one that starts mid-pulse;
- abort an open window with `clear` and then measure again.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

  // Strobes issued by the control FSM to the flag datapath
  typedef struct packed {
    logic restart;
    logic openWin;
    logic closeWin;
  } winStrobes_t;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2,
    ST_DONE   = 2'd3
  } winState_t;

endpackage

// File: rtl/pwg_datapath.sv
module pwg_datapath
  import pwg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sigIn,
  input  logic        invertPol,
  input  winStrobes_t strobes,
  output logic        activeLevel,
  output logic        activeRise,
  output logic        activeFall,
  output logic        countEn,
  output logic        convDone
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] syncReg;
  logic              polPrev;

  // Synchronizer chain on the reference clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_MSB-1:0], sigIn};
  end

  // Polarity applied before edge detection
  assign activeLevel = syncReg[SYNC_MSB] ^ invertPol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) polPrev <= 1'b0;
    else       polPrev <= activeLevel;
  end

  assign activeRise = activeLevel & ~polPrev;
  assign activeFall = ~activeLevel & polPrev;

  // Status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countEn  <= 1'b0;
      convDone <= 1'b0;
    end else if (strobes.restart) begin
      countEn  <= 1'b0;
      convDone <= 1'b0;
    end else if (strobes.closeWin) begin
      countEn  <= 1'b0;
      convDone <= 1'b1;
    end else if (strobes.openWin) begin
      countEn  <= 1'b1;
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(countEn && convDone)); // R6

  AST_OPEN_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(countEn) |-> $past(activeRise)); // R2

  AST_CLOSE_SETS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(countEn) && !$past(strobes.restart)) |-> convDone); // R6

  AST_NO_REOPEN: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !strobes.restart) |=> !countEn); // R7

endmodule

// File: rtl/pwg_control.sv
module pwg_control
  import pwg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        widthMode,
  input  logic        activeLevel,
  input  logic        activeRise,
  input  logic        activeFall,
  output winStrobes_t strobes
);

  winState_t state, stateNext;
  logic      closeEdge;

  assign closeEdge = widthMode ? activeFall : activeRise;

  always_comb begin
    strobes.restart  = clear;
    strobes.openWin  = !clear && (state == ST_ARMED) && activeRise;
    strobes.closeWin = !clear && (state == ST_OPEN) && closeEdge;
  end

  always_comb begin
    stateNext = state;
    if (clear) begin
      stateNext = ST_SETTLE;
    end else begin
      unique case (state)
        ST_SETTLE: if (!activeLevel)     stateNext = ST_ARMED;
        ST_ARMED:  if (strobes.openWin)  stateNext = ST_OPEN;
        ST_OPEN:   if (strobes.closeWin) stateNext = ST_DONE;
        ST_DONE:   stateNext = ST_DONE;
        default:   stateNext = ST_SETTLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SETTLE;
    else       state <= stateNext;
  end

  AST_ARMED_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && activeLevel) |-> activeRise); // R8

  AST_WIDTH_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN && widthMode) |-> (activeLevel || activeFall)); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && !clear) |=> (state == ST_DONE)); // R7

  AST_CLEAR_REARMS: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (state == ST_SETTLE)); // R9

endmodule

// File: rtl/pulse_window_gen.sv
module pulse_window_gen
  import pwg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic sigIn,
  input  logic widthMode,
  input  logic invertPol,
  output logic countEn,
  output logic convDone
);

  winStrobes_t strobes;
  logic        activeLevel;
  logic        activeRise;
  logic        activeFall;

  pwg_control ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .clear       (clear),
    .widthMode   (widthMode),
    .activeLevel (activeLevel),
    .activeRise  (activeRise),
    .activeFall  (activeFall),
    .strobes     (strobes)
  );

  pwg_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .sigIn       (sigIn),
    .invertPol   (invertPol),
    .strobes     (strobes),
    .activeLevel (activeLevel),
    .activeRise  (activeRise),
    .activeFall  (activeFall),
    .countEn     (countEn),
    .convDone    (convDone)
  );

endmodule

// File: tb/pulse_window_gen_tb.sv
`timescale 1ns/1ps
module pulse_window_gen_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic sigIn = 1'b0;
  logic widthMode = 1'b0;
  logic invertPol = 1'b0;
  logic countEn;
  logic convDone;

  int checks = 0;
  int errors = 0;
  int highCount = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  pulse_window_gen dut_i (
    .clk(clk), .rstN(rstN), .clear(clear), .sigIn(sigIn),
    .widthMode(widthMode), .invertPol(invertPol),
    .countEn(countEn), .convDone(convDone)
  );

  localparam int NVEC = 6;
  localparam bit VecWidth [NVEC] = '{0, 0, 1, 1, 0, 1};
  localparam bit VecInv   [NVEC] = '{0, 0, 0, 0, 1, 1};
  localparam int VecAct   [NVEC] = '{4, 1, 7, 1, 3, 5};
  localparam int VecIdle  [NVEC] = '{6, 1, 3, 5, 9, 2};

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // count window cycles while driving the input
  task automatic drive(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (countEn) highCount++;
      sigIn = lvl;
    end
  endtask

  task automatic pulseClear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  task automatic setup(input bit wm, input bit inv, input logic rawLvl);
    @(negedge clk);
    widthMode = wm;
    invertPol = inv;
    sigIn = rawLvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 countEn in reset", countEn, 0);
    check("R1 convDone in reset", convDone, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 countEn after reset", countEn, 0);
    check("R1 convDone after reset", convDone, 0);

    // Vector table: R2 period, R3 width, R4 polarity, R7 sticky done
    for (int v = 0; v < NVEC; v++) begin
      logic inact;
      int expWin;
      inact = VecInv[v];
      expWin = VecWidth[v] ? VecAct[v] : VecAct[v] + VecIdle[v];
      setup(VecWidth[v], VecInv[v], inact);
      pulseClear();
      highCount = 0;
      drive(inact, 4);
      for (int p = 0; p < 3; p++) begin
        drive(!inact, VecAct[v]);
        drive(inact, VecIdle[v]);
      end
      drive(inact, 6);
      check(VecWidth[v] ? "R3/R4 window length" : "R2/R4 window length", highCount, expWin);
      check("R7 convDone held", convDone, 1);
      check("R7 countEn stays low", countEn, 0);
    end

    // R5 / R6 latency at both window ends, period mode
    setup(0, 0, 1'b0);
    pulseClear();
    repeat (4) @(negedge clk);
    sigIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 countEn two edges after rise", countEn, 0);
    @(negedge clk);
    check("R5 countEn three edges after rise", countEn, 1);
    sigIn = 1'b0;
    repeat (3) @(negedge clk);
    sigIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 countEn before close", countEn, 1);
    check("R6 convDone before close", convDone, 0);
    @(negedge clk);
    check("R6 countEn at close", countEn, 0);
    check("R6 convDone at close", convDone, 1);

    // R8 arm during an active pulse, width mode
    setup(1, 0, 1'b1);
    pulseClear();
    highCount = 0;
    drive(1'b1, 5);
    drive(1'b0, 4);
    drive(1'b1, 3);
    drive(1'b0, 8);
    check("R8 pulse in progress skipped", highCount, 3);
    check("R8 convDone", convDone, 1);

    // R9 abort an open window then measure again
    setup(0, 0, 1'b0);
    pulseClear();
    repeat (4) @(negedge clk);
    sigIn = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 window open before abort", countEn, 1);
    pulseClear();
    check("R9 countEn after abort", countEn, 0);
    check("R9 convDone after abort", convDone, 0);
    highCount = 0;
    drive(1'b1, 3);
    drive(1'b0, 3);
    drive(1'b1, 2);
    drive(1'b0, 4);
    drive(1'b1, 2);
    drive(1'b0, 6);
    check("R9 window after re-arm", highCount, 6);
    check("R9 convDone after re-arm", convDone, 1);

    report();
  end

endmodule